// File: doc/BRIEF.md
# Folded 64-Point Inverse FFT

This block computes a 64-point inverse discrete Fourier transform for the modulation path of an OFDM transmitter. A frame of 64 complex fixed-point samples is taken in one handshake. The block does not lay out three radix-4 stages in space. It keeps a single stage of sixteen 4-input butterflies and a fixed reorder network, and a 2-bit pass counter feeds the stage register back through that hardware three times. The finished spectrum is then held on a wide output bus until the consumer takes it.

On acceptance, the frame is written into the stage register in base-4 digit-reversed order. Each pass does three things to every group of four neighbouring positions: it multiplies each position by a twiddle constant chosen by pass, butterfly and lane, combines the four with a radix-4 butterfly, and moves the results through a digit rotation. After the third pass, position k holds output bin k in natural order. One frame takes five clock cycles from acceptance to the next possible acceptance. At a clock of 1.25 MHz or more, this meets a requirement of one symbol every 4 µs.

Top module: `ifft64_fold`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1 and `out_valid` is 0.
- R2: Sample n of a frame occupies bits [32n+31:32n] of `in_data` and `out_data`. The real part is in the upper 16 bits and the imaginary part in the lower 16 bits. Both are two's complement with 15 fractional bits.
- R3: Input sample n, with base-4 digits n = 16a+4b+c, is loaded into register position 16c+4b+a.
- R4: In pass s, lane m (0..3) of butterfly i (positions 4i..4i+3) is multiplied by the complex constant round(32768·cos θ) + j·round(32768·sin θ). The angle is θ = 2π·m·g/64, where g is 0 in pass 0, 4·(i div 4) in pass 1 and i in pass 2. Each component is clamped to ±32767.
- R5: Each complex product component is computed exactly, then (p + 16384) is shifted arithmetically right by 15 and saturated to [-32768, 32767].
- R6: The four rounded products m0..m3 are combined as y0=m0+m2, y1=m0−m2, y2=m1+m3, y3=j·(m1−m3), then z0=y0+y2, z1=y1+y3, z2=y0−y2, z3=y1−y3. Each component is kept exact and then saturated to 16 bits.
- R7: After the butterflies of a pass, the value at position 16a+4b+c moves to position 16c+4a+b. After the third pass, position k holds bin k.
- R8: `out_valid` rises in the third cycle after the accepting clock edge, that is, after exactly three passes.
- R9: `in_ready` is 0 from the accepting edge until the result has been taken. `in_valid` and `in_data` have no effect during that time. `in_ready` and `out_valid` are never both 1.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R11: In the cycle after the result is taken, `in_ready` is 1 again. With both sides always willing, a new frame is accepted every five cycles.
- R12: For inputs whose components lie within ±300, every output component is within 64 LSB of the unscaled sum Σ x[n]·e^{+j2πnk/64}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a frame |
| in_ready | output | 1 | Block is idle and takes a frame |
| in_data | input | 2048 | 64 complex input samples, packed per R2 |
| out_valid | output | 1 | Transformed frame is available |
| out_ready | input | 1 | Consumer takes the frame |
| out_data | output | 2048 | 64 complex output bins, packed per R2 |

## Verification
The bench builds the block with the default sample width of 16 bits. At that width the Q1.15 twiddle constants, the ±1 clamp at angle zero and the 16-bit saturation after a butterfly can all be reached with ordinary input values: full-scale frames and a constant frame of 16000 drive the bin-zero path into saturation, and amplitudes of at most ±300 leave every stage unsaturated, so the results can be compared with a floating-point transform. Stalls on both handshakes, including offers made while the block is busy, are mixed with back-to-back traffic to exercise the five-cycle frame period.

// File: rtl/ifft64_fold.sv
module ifft64_fold #(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [64*2*DW-1:0]  in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [64*2*DW-1:0]  out_data
);
  localparam int NPT = 64;
  localparam int NBF = NPT / 4;
  localparam int SW  = 2 * DW;
  localparam int PW  = 2 * DW + 1;
  localparam int ZW  = DW + 2;
  localparam int FR  = DW - 1;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DONE = 2'd2;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FR - 1);

  // round(2^FR * cos(pi*k/32)) for k in 0..16, Taylor series in Q30
  function automatic longint cos_q(int k);
    longint x, x2, term, acc;
    x = (64'sd3373259426 * longint'(k)) / 64'sd32;
    x2 = (x * x) >>> 30;
    term = 64'sd1 <<< 30;
    acc = term;
    for (int n = 1; n <= 10; n++) begin
      term = -((term * x2) >>> 30) / longint'((2*n-1) * (2*n));
      acc = acc + term;
    end
    acc = (acc + (64'sd1 <<< (29 - FR))) >>> (30 - FR);
    if (acc > (64'sd1 <<< FR) - 64'sd1) acc = (64'sd1 <<< FR) - 64'sd1;
    return acc;
  endfunction

  function automatic longint tw_cos(int e);
    if (e <= 16)      return cos_q(e);
    else if (e <= 32) return -cos_q(32 - e);
    else if (e <= 48) return -cos_q(e - 32);
    else              return cos_q(64 - e);
  endfunction

  function automatic longint tw_sin(int e);
    return tw_cos((e + 48) % 64);
  endfunction

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] hi, lo;
    hi = {{(DW+2){1'b0}}, {(DW-1){1'b1}}};
    lo = {{(DW+2){1'b1}}, {(DW-1){1'b0}}};
    if (v > hi)      return hi[DW-1:0];
    else if (v < lo) return lo[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  logic [1:0]    state, stg;
  logic [SW-1:0] st  [NPT];
  logic [SW-1:0] ld  [NPT];
  logic [SW-1:0] nxt [NPT];

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);

  for (genvar n = 0; n < NPT; n++) begin : g_io
    assign ld[16*(n%4) + 4*((n/4)%4) + n/16] = in_data[n*SW +: SW];
    assign out_data[n*SW +: SW] = st[n];
  end

  for (genvar b = 0; b < NBF; b++) begin : g_bf
    logic signed [DW-1:0] mr [4];
    logic signed [DW-1:0] mi [4];
    logic signed [ZW-1:0] zr [4];
    logic signed [ZW-1:0] zi [4];
    logic signed [ZW-1:0] y0r, y0i, y1r, y1i, y2r, y2i, y3r, y3i;

    for (genvar m = 0; m < 4; m++) begin : g_mul
      localparam int E1 = (m * (b & 12)) % 64;
      localparam int E2 = (m * b) % 64;
      localparam logic signed [DW-1:0] C0 = DW'(tw_cos(0));
      localparam logic signed [DW-1:0] S0 = DW'(tw_sin(0));
      localparam logic signed [DW-1:0] C1 = DW'(tw_cos(E1));
      localparam logic signed [DW-1:0] S1 = DW'(tw_sin(E1));
      localparam logic signed [DW-1:0] C2 = DW'(tw_cos(E2));
      localparam logic signed [DW-1:0] S2 = DW'(tw_sin(E2));
      logic signed [DW-1:0] xr, xi, wr, wi;
      logic signed [PW-1:0] pr, pi;
      assign xr = st[4*b+m][SW-1:DW];
      assign xi = st[4*b+m][DW-1:0];
      assign wr = (stg == 2'd0) ? C0 : (stg == 2'd1) ? C1 : C2;
      assign wi = (stg == 2'd0) ? S0 : (stg == 2'd1) ? S1 : S2;
      assign pr = PW'(xr) * PW'(wr) - PW'(xi) * PW'(wi) + HALF;
      assign pi = PW'(xr) * PW'(wi) + PW'(xi) * PW'(wr) + HALF;
      assign mr[m] = sat_dw(pr >>> FR);
      assign mi[m] = sat_dw(pi >>> FR);
    end

    assign y0r = ZW'(mr[0]) + ZW'(mr[2]);
    assign y0i = ZW'(mi[0]) + ZW'(mi[2]);
    assign y1r = ZW'(mr[0]) - ZW'(mr[2]);
    assign y1i = ZW'(mi[0]) - ZW'(mi[2]);
    assign y2r = ZW'(mr[1]) + ZW'(mr[3]);
    assign y2i = ZW'(mi[1]) + ZW'(mi[3]);
    assign y3r = ZW'(mi[3]) - ZW'(mi[1]);
    assign y3i = ZW'(mr[1]) - ZW'(mr[3]);
    assign zr[0] = y0r + y2r;  assign zi[0] = y0i + y2i;
    assign zr[1] = y1r + y3r;  assign zi[1] = y1i + y3i;
    assign zr[2] = y0r - y2r;  assign zi[2] = y0i - y2i;
    assign zr[3] = y1r - y3r;  assign zi[3] = y1i - y3i;

    for (genvar k = 0; k < 4; k++) begin : g_out
      assign nxt[16*k + b] = {sat_dw(PW'(zr[k])), sat_dw(PW'(zi[k]))};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      stg   <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          stg   <= 2'd0;
        end
        ST_RUN: if (stg == 2'd2) state <= ST_DONE;
                else stg <= stg + 2'd1;
        default: if (out_ready) state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_IDLE && in_valid) st <= ld;
    else if (state == ST_RUN)         st <= nxt;
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R9
  AST_THREE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 4)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
  AST_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid); // R11
endmodule

// File: tb/ifft64_fold_tb.sv
module ifft64_fold_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int SW  = 2 * DW;
  localparam int NPT = 64;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [NPT*SW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [NPT*SW-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifft64_fold #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int n_chk = 0, n_fail = 0;
  int drv_re[NPT], drv_im[NPT];
  int in_re[NPT], in_im[NPT];
  int exp_re[NPT], exp_im[NPT];
  int m_st = 0;
  bit float_mode = 0, m_float = 0, float_done = 0;
  bit want_all = 0, m_all = 0;
  bit want_dc = 0, m_dc = 0;
  int want_val = 0, m_val = 0;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int twid(int e, bit want_sin);
    real v;
    int r;
    v = 32768.0 * (want_sin ? $sin(2.0 * PI * e / 64.0) : $cos(2.0 * PI * e / 64.0));
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    if (r > 32767)  r = 32767;
    if (r < -32767) r = -32767;
    return r;
  endfunction

  function automatic int rnd15(longint p);
    return sat16((p + 16384) >>> 15);
  endfunction

  // Reference built from the requirement text: load order, twiddles, butterfly, reorder
  task automatic run_model();
    int ar[NPT], ai[NPT], tr[NPT], ti[NPT];
    for (int n = 0; n < NPT; n++) begin
      ar[(n % 4) * 16 + ((n / 4) % 4) * 4 + n / 16] = in_re[n];
      ai[(n % 4) * 16 + ((n / 4) % 4) * 4 + n / 16] = in_im[n];
    end
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < 16; i++) begin
        longint pr[4], pi[4], yr[4], yi[4], zr[4], zi[4];
        for (int m = 0; m < 4; m++) begin
          int g, wr, wi;
          g = (s == 0) ? 0 : (s == 1) ? 4 * (i / 4) : i;
          wr = twid((m * g) % 64, 1'b0);
          wi = twid((m * g) % 64, 1'b1);
          pr[m] = rnd15(longint'(ar[4*i+m]) * wr - longint'(ai[4*i+m]) * wi);
          pi[m] = rnd15(longint'(ar[4*i+m]) * wi + longint'(ai[4*i+m]) * wr);
        end
        yr[0] = pr[0] + pr[2]; yi[0] = pi[0] + pi[2];
        yr[1] = pr[0] - pr[2]; yi[1] = pi[0] - pi[2];
        yr[2] = pr[1] + pr[3]; yi[2] = pi[1] + pi[3];
        yr[3] = -(pi[1] - pi[3]); yi[3] = pr[1] - pr[3];
        zr[0] = yr[0] + yr[2]; zi[0] = yi[0] + yi[2];
        zr[1] = yr[1] + yr[3]; zi[1] = yi[1] + yi[3];
        zr[2] = yr[0] - yr[2]; zi[2] = yi[0] - yi[2];
        zr[3] = yr[1] - yr[3]; zi[3] = yi[1] - yi[3];
        for (int k = 0; k < 4; k++) begin
          tr[4*i+k] = sat16(zr[k]);
          ti[4*i+k] = sat16(zi[k]);
        end
      end
      for (int p = 0; p < NPT; p++) begin
        ar[(p % 4) * 16 + (p / 16) * 4 + (p / 4) % 4] = tr[p];
        ai[(p % 4) * 16 + (p / 16) * 4 + (p / 4) % 4] = ti[p];
      end
    end
    for (int k = 0; k < NPT; k++) begin
      exp_re[k] = ar[k];
      exp_im[k] = ai[k];
    end
  endtask

  function automatic int out_re(int k);
    return int'($signed(out_data[k*SW+DW +: DW]));
  endfunction
  function automatic int out_im(int k);
    return int'($signed(out_data[k*SW +: DW]));
  endfunction

  task automatic compare_outputs();
    check(in_ready === (m_st == 0), "R9/R11", "in_ready", longint'(in_ready), longint'(m_st == 0));
    check(out_valid === (m_st == 4), "R8/R10", "out_valid", longint'(out_valid), longint'(m_st == 4));
    if (m_st == 4 && out_valid === 1'b1) begin
      int bad = -1;
      for (int k = 0; k < NPT; k++)
        if (bad < 0 && (out_re(k) != exp_re[k] || out_im(k) != exp_im[k])) bad = k;
      if (bad < 0) check(1'b1, "R2/R3/R4/R5/R6/R7", "bins", 0, 0);
      else check(1'b0, "R2/R3/R4/R5/R6/R7", $sformatf("bin %0d real", bad), out_re(bad), exp_re[bad]);
      if (!float_done) begin
        float_done = 1;
        if (m_all) begin
          int badc = -1;
          for (int k = 0; k < NPT; k++)
            if (badc < 0 && (out_re(k) != m_val || out_im(k) != 0)) badc = k;
          check(badc < 0, "R3/R7", "impulse gives flat spectrum", (badc < 0) ? m_val : out_re(badc), m_val);
        end
        if (m_dc)
          check(out_re(0) == 32767 && out_im(0) == 0, "R6", "bin 0 saturates", out_re(0), 32767);
        if (m_float) begin
          real worst = 0.0;
          for (int k = 0; k < NPT; k++) begin
            real sr = 0.0, si = 0.0, dr, di;
            for (int n = 0; n < NPT; n++) begin
              real th = 2.0 * PI * ((n * k) % 64) / 64.0;
              sr += in_re[n] * $cos(th) - in_im[n] * $sin(th);
              si += in_re[n] * $sin(th) + in_im[n] * $cos(th);
            end
            dr = out_re(k) - sr; if (dr < 0.0) dr = -dr;
            di = out_im(k) - si; if (di < 0.0) di = -di;
            if (dr > worst) worst = dr;
            if (di > worst) worst = di;
          end
          check(worst <= 64.0, "R12", "max error vs inverse DFT", longint'($rtoi(worst)), 64);
        end
      end
    end
  endtask

  task automatic tick(bit iv, bit orr);
    @(negedge clk);
    compare_outputs();
    in_valid  = iv;
    out_ready = orr;
    for (int n = 0; n < NPT; n++)
      in_data[n*SW +: SW] = {DW'(drv_re[n]), DW'(drv_im[n])};
    if (m_st == 0) begin
      if (iv) begin
        for (int n = 0; n < NPT; n++) begin
          in_re[n] = drv_re[n];
          in_im[n] = drv_im[n];
        end
        run_model();
        m_float = float_mode; m_all = want_all; m_dc = want_dc; m_val = want_val;
        want_all = 0; want_dc = 0;
        float_done = 0;
        m_st = 1;
      end
    end else if (m_st < 4) m_st++;
    else if (orr) m_st = 0;
  endtask

  task automatic fill_rand(int amp);
    for (int n = 0; n < NPT; n++) begin
      drv_re[n] = int'($urandom_range(2 * amp)) - amp;
      drv_im[n] = int'($urandom_range(2 * amp)) - amp;
    end
  endtask

  task automatic fill_const(int re, int im);
    for (int n = 0; n < NPT; n++) begin
      drv_re[n] = re;
      drv_im[n] = im;
    end
  endtask

  initial begin
    fill_const(0, 0);
    repeat (2) @(negedge clk);
    check(in_ready === 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
    check(out_valid === 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R7: impulse at sample 0 gives a flat spectrum
    fill_const(0, 0); drv_re[0] = 1000;
    want_all = 1; want_val = 1000; float_mode = 1;
    tick(1, 1);
    repeat (6) tick(0, 1);

    // R9 R10: offers while busy are ignored, output held under back-pressure
    fill_const(0, 0); drv_re[1] = 2000;
    tick(1, 0);
    fill_rand(300);
    repeat (8) tick(1, 0);
    tick(0, 1);
    repeat (3) tick(0, 1);

    // R12: single tone
    for (int n = 0; n < NPT; n++) begin
      drv_re[n] = $rtoi(300.0 * $cos(2.0 * PI * 3 * n / 64.0));
      drv_im[n] = $rtoi(300.0 * $sin(2.0 * PI * 3 * n / 64.0));
    end
    tick(1, 1);
    repeat (6) tick(0, 1);

    // R11: back-to-back small frames
    repeat (40) begin fill_rand(300); tick(1, 1); end

    // random handshakes on both sides
    repeat (300) begin
      fill_rand(300);
      tick(bit'($urandom_range(1)), bit'($urandom_range(1)));
    end
    repeat (6) tick(0, 1);

    // R6: constant frame drives bin 0 into saturation
    float_mode = 0;
    fill_const(16000, 0); want_dc = 1;
    tick(1, 1);
    repeat (6) tick(0, 1);

    // R4 R5 R6: full-scale random frames with random back-pressure
    repeat (200) begin
      fill_rand(32767);
      tick(bit'($urandom_range(1)), bit'($urandom_range(1)));
    end
    repeat (8) tick(0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule